// File: doc/BRIEF.md
# Front-Panel Frequency and Waveform Editor

This block is the control core behind a two-line front-panel editor for a tone generator. The top line shows a waveform slot number and the bottom line a six-digit decimal frequency written as NNNNN.N Hz. An operator moves between the lines with a toggle switch, steps a cursor across the frequency digits with an Advance button, and raises the digit under the cursor (or picks the next stored waveform) with an Increment button. Every digit is edited on its own: a digit that passes 9 returns to 0 and leaves its neighbours alone.

The switch and button levels arrive already debounced. They are only looked at on a periodic sample strobe (for example every 50 ms), and a host-mode input freezes the editor while a remote controller owns the generator. From the edited digits the block derives a 20-bit oscillator step in units of 0.1 Hz, clamped to the legal 0.1 Hz to 20 kHz span. It also raises a one-cycle notice whenever the frequency or the slot changes.

Top module: `panel_editor`

## Requirements
- R1: After reset the slot is 0, the frequency digits read 01000.0, the cursor sits on the top line at digit position 0, `nco_inc` is 10000, and both pulse outputs are low.
- R2: At each strobe with `host_mode` low, `cursor_line` takes the level of `line_sel` (0 = waveform line, 1 = frequency line). Button actions at that strobe use this same level.
- R3: An Advance press on the frequency line moves `cursor_digit` from position p to p+1, and from 5 back to 0. Position 0 is the ten-thousands digit and 5 is the tenths digit; the decimal point has no position.
- R4: An Advance press on the waveform line leaves the cursor, the digits and the slot unchanged.
- R5: An Increment press on the frequency line adds one to the digit under the cursor, turns 9 into 0, and changes no other digit. In `freq_bcd`, bits [3:0] hold tenths and bits [23:20] hold ten-thousands, with 4 bits per digit.
- R6: An Increment press on the waveform line selects the next slot, counting upward, whose `slot_mask` bit is 1. The count wraps from 13 to 0. If no other slot is occupied, the slot is kept. `slot_req` pulses for one cycle only when the slot actually changes.
- R7: A press is counted only when a button is high at a strobe and was low at the previous strobe. A button held across several strobes acts once.
- R8: While `host_mode` is high at a strobe, that strobe changes no output state. The remembered button levels still follow the inputs.
- R9: `nco_inc` is the frequency in tenths of a hertz, clamped to the range 1 to 200000. It reflects a digit change one clock after `freq_bcd` shows it.
- R10: `upd_pulse` is high for exactly the one cycle in which a new frequency or a new slot first appears on the outputs.
- R11: When Advance and Increment are both pressed at the same strobe on the frequency line, the increment applies to the digit under the old cursor position, and then the cursor advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Sample strobe, one cycle wide |
| host_mode | input | 1 | High while a remote host owns the generator |
| line_sel | input | 1 | Line toggle: 0 waveform, 1 frequency |
| adv_btn | input | 1 | Debounced Advance button level |
| inc_btn | input | 1 | Debounced Increment button level |
| slot_mask | input | 14 | Occupancy flag per waveform slot |
| cursor_line | output | 1 | Line holding the cursor |
| cursor_digit | output | 3 | Frequency digit under the cursor, 0..5 |
| freq_bcd | output | 24 | Six BCD frequency digits |
| slot | output | 4 | Selected waveform slot |
| slot_req | output | 1 | One-cycle request to load the new slot |
| upd_pulse | output | 1 | One-cycle notice of a frequency or slot change |
| nco_inc | output | 20 | Oscillator step in 0.1 Hz units |

## Verification
A strobe is taken at one rising edge. The cursor, digits, slot and both pulses show its effect right after that same edge, while `nco_inc` follows one edge later because its conversion stage is registered. The bench raises the strobe for one cycle from a falling edge. It reads the cursor, digits, slot and pulses at the next falling edge, then reads `nco_inc` one falling edge after that, when the pulses are already low again. A reference model in the bench is updated at each strobe and supplies all expected values.

// File: rtl/pe_pkg.sv
package pe_pkg;

  localparam int NDIG  = 6;
  localparam int DIG_W = 4;

  function automatic int unsigned pow10(input int n);
    int unsigned r;
    r = 1;
    for (int i = 0; i < n; i++) r = r * 10;
    return r;
  endfunction

  function automatic logic [DIG_W-1:0] digit_of(input int unsigned v, input int pos);
    return DIG_W'((v / pow10(NDIG - 1 - pos)) % 10);
  endfunction

endpackage

// File: rtl/pe_sampler.sv
module pe_sampler (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic host_mode,
  input  logic adv_btn,
  input  logic inc_btn,
  output logic act,
  output logic adv_ev,
  output logic inc_ev
);

  logic adv_q, inc_q;

  // the remembered levels follow every strobe, host mode or not
  always_ff @(posedge clk) begin
    if (rst) begin
      adv_q <= 1'b0;
      inc_q <= 1'b0;
    end else if (tick) begin
      adv_q <= adv_btn;
      inc_q <= inc_btn;
    end
  end

  always_comb begin
    act    = tick & ~host_mode;
    adv_ev = act & adv_btn & ~adv_q;
    inc_ev = act & inc_btn & ~inc_q;
  end

endmodule

// File: rtl/pe_freq.sv
module pe_freq
  import pe_pkg::*;
#(
  parameter int unsigned RESET_TENTHS = 10000,
  localparam int CUR_W = $clog2(NDIG),
  localparam int BCD_W = NDIG * DIG_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_dig,
  input  logic             move_cur,
  output logic [BCD_W-1:0] freq_bcd,
  output logic [CUR_W-1:0] cursor_digit,
  output logic             freq_chg
);

  logic [DIG_W-1:0] dig [NDIG];
  logic [CUR_W-1:0] cur;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NDIG; k++) dig[k] <= digit_of(RESET_TENTHS, k);
      cur      <= '0;
      freq_chg <= 1'b0;
    end else begin
      freq_chg <= step_dig;
      if (step_dig) begin
        for (int k = 0; k < NDIG; k++) begin
          if (CUR_W'(k) == cur)
            dig[k] <= (dig[k] == DIG_W'(9)) ? '0 : dig[k] + DIG_W'(1);
        end
      end
      if (move_cur)
        cur <= (cur == CUR_W'(NDIG - 1)) ? '0 : cur + CUR_W'(1);
    end
  end

  // position 0 (ten-thousands) lands in the top nibble
  for (genvar g = 0; g < NDIG; g++) begin : g_pack
    assign freq_bcd[DIG_W*(NDIG-1-g) +: DIG_W] = dig[g];
  end
  assign cursor_digit = cur;

  assert_cursor_range_R3: assert property (@(posedge clk) disable iff (rst)
    cursor_digit < CUR_W'(NDIG));

  assert_cursor_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    (move_cur && cursor_digit == CUR_W'(NDIG - 1)) |=> cursor_digit == '0);

  for (genvar g = 0; g < NDIG; g++) begin : g_chk
    assert_digit_decimal_R5: assert property (@(posedge clk) disable iff (rst)
      freq_bcd[DIG_W*g +: DIG_W] <= DIG_W'(9));
  end

endmodule

// File: rtl/pe_slot.sv
module pe_slot #(
  parameter int NSLOT = 14,
  localparam int SLOT_W = $clog2(NSLOT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_slot,
  input  logic [NSLOT-1:0]  slot_mask,
  output logic [SLOT_W-1:0] slot,
  output logic              slot_req
);

  logic [SLOT_W-1:0] nxt;
  logic              found;
  logic [SLOT_W:0]   idx;

  // upward search from the slot after the current one, wrapping past the top
  always_comb begin
    nxt   = slot;
    found = 1'b0;
    idx   = '0;
    for (int k = 1; k < NSLOT; k++) begin
      idx = {1'b0, slot} + (SLOT_W+1)'(k);
      if (idx >= (SLOT_W+1)'(NSLOT)) idx = idx - (SLOT_W+1)'(NSLOT);
      if (!found && slot_mask[idx[SLOT_W-1:0]]) begin
        nxt   = idx[SLOT_W-1:0];
        found = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slot     <= '0;
      slot_req <= 1'b0;
    end else begin
      slot_req <= step_slot && (nxt != slot);
      if (step_slot) slot <= nxt;
    end
  end

  assert_slot_range_R6: assert property (@(posedge clk) disable iff (rst)
    slot < SLOT_W'(NSLOT));

  assert_req_occupied_R6: assert property (@(posedge clk) disable iff (rst)
    slot_req |-> ((($past(slot_mask)) >> slot) & NSLOT'(1)) != '0);

  assert_req_on_change_R6: assert property (@(posedge clk) disable iff (rst)
    (slot != $past(slot)) |-> slot_req);

endmodule

// File: rtl/pe_conv.sv
module pe_conv
  import pe_pkg::*;
#(
  parameter int INC_W = 20,
  parameter int unsigned FMIN = 1,
  parameter int unsigned FMAX = 200000,
  parameter int unsigned RESET_TENTHS = 10000,
  localparam int BCD_W = NDIG * DIG_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [BCD_W-1:0] freq_bcd,
  output logic [INC_W-1:0] nco_inc
);

  int unsigned sum;
  int unsigned lim;

  always_comb begin
    sum = 0;
    for (int k = 0; k < NDIG; k++)
      sum = sum + 32'(freq_bcd[DIG_W*k +: DIG_W]) * pow10(k);
    if (sum < FMIN)      lim = FMIN;
    else if (sum > FMAX) lim = FMAX;
    else                 lim = sum;
  end

  always_ff @(posedge clk) begin
    if (rst) nco_inc <= INC_W'(RESET_TENTHS);
    else     nco_inc <= INC_W'(lim);
  end

  assert_inc_bounds_R9: assert property (@(posedge clk) disable iff (rst)
    (nco_inc >= INC_W'(FMIN)) && (nco_inc <= INC_W'(FMAX)));

  assert_inc_follows_R9: assert property (@(posedge clk) disable iff (rst)
    $stable(freq_bcd) |=> $stable(nco_inc));

endmodule

// File: rtl/panel_editor.sv
module panel_editor
  import pe_pkg::*;
#(
  parameter int NSLOT = 14,
  parameter int INC_W = 20,
  parameter int unsigned FMIN = 1,
  parameter int unsigned FMAX = 200000,
  parameter int unsigned RESET_TENTHS = 10000,
  localparam int SLOT_W = $clog2(NSLOT),
  localparam int CUR_W  = $clog2(NDIG),
  localparam int BCD_W  = NDIG * DIG_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              host_mode,
  input  logic              line_sel,
  input  logic              adv_btn,
  input  logic              inc_btn,
  input  logic [NSLOT-1:0]  slot_mask,
  output logic              cursor_line,
  output logic [CUR_W-1:0]  cursor_digit,
  output logic [BCD_W-1:0]  freq_bcd,
  output logic [SLOT_W-1:0] slot,
  output logic              slot_req,
  output logic              upd_pulse,
  output logic [INC_W-1:0]  nco_inc
);

  logic act, adv_ev, inc_ev, freq_chg;

  pe_sampler i_sampler (
    .clk(clk), .rst(rst), .tick(tick), .host_mode(host_mode),
    .adv_btn(adv_btn), .inc_btn(inc_btn),
    .act(act), .adv_ev(adv_ev), .inc_ev(inc_ev)
  );

  always_ff @(posedge clk) begin
    if (rst)      cursor_line <= 1'b0;
    else if (act) cursor_line <= line_sel;
  end

  pe_freq #(.RESET_TENTHS(RESET_TENTHS)) i_freq (
    .clk(clk), .rst(rst),
    .step_dig(inc_ev & line_sel), .move_cur(adv_ev & line_sel),
    .freq_bcd(freq_bcd), .cursor_digit(cursor_digit), .freq_chg(freq_chg)
  );

  pe_slot #(.NSLOT(NSLOT)) i_slot (
    .clk(clk), .rst(rst), .step_slot(inc_ev & ~line_sel),
    .slot_mask(slot_mask), .slot(slot), .slot_req(slot_req)
  );

  pe_conv #(.INC_W(INC_W), .FMIN(FMIN), .FMAX(FMAX), .RESET_TENTHS(RESET_TENTHS)) i_conv (
    .clk(clk), .rst(rst), .freq_bcd(freq_bcd), .nco_inc(nco_inc)
  );

  assign upd_pulse = freq_chg | slot_req;

  assert_host_freeze_R8: assert property (@(posedge clk) disable iff (rst)
    host_mode |=> ($stable(freq_bcd) && $stable(slot) && $stable(cursor_line)
                   && $stable(cursor_digit)));

  assert_wave_adv_inert_R4: assert property (@(posedge clk) disable iff (rst)
    (tick && !host_mode && !line_sel) |=> ($stable(cursor_digit) && $stable(freq_bcd)));

  assert_upd_on_change_R10: assert property (@(posedge clk) disable iff (rst)
    ((freq_bcd != $past(freq_bcd)) || (slot != $past(slot))) |-> upd_pulse);

  assert_no_idle_edit_R7: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(freq_bcd) && $stable(slot) && $stable(cursor_digit)));

endmodule

// File: tb/test_panel_editor.sv
module test_panel_editor;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0, host_mode = 1'b0, line_sel = 1'b0;
  logic        adv_btn = 1'b0, inc_btn = 1'b0;
  logic [13:0] slot_mask = 14'h3FFF;
  logic        cursor_line;
  logic [2:0]  cursor_digit;
  logic [23:0] freq_bcd;
  logic [3:0]  slot;
  logic        slot_req, upd_pulse;
  logic [19:0] nco_inc;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  int m_dig [6];
  int m_cur, m_line, m_slot;
  bit m_pa, m_pi;

  always #5 clk = ~clk;

  panel_editor i_panel_editor (
    .clk(clk), .rst(rst), .tick(tick), .host_mode(host_mode), .line_sel(line_sel),
    .adv_btn(adv_btn), .inc_btn(inc_btn), .slot_mask(slot_mask),
    .cursor_line(cursor_line), .cursor_digit(cursor_digit), .freq_bcd(freq_bcd),
    .slot(slot), .slot_req(slot_req), .upd_pulse(upd_pulse), .nco_inc(nco_inc)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int model_bcd();
    int r = 0;
    for (int k = 0; k < 6; k++) r = r | (m_dig[k] << (4 * (5 - k)));
    return r;
  endfunction

  function automatic int model_inc();
    int v = 0;
    for (int k = 0; k < 6; k++) v = v * 10 + m_dig[k];
    if (v < 1) v = 1;
    if (v > 200000) v = 200000;
    return v;
  endfunction

  function automatic int next_slot(input int cur, input logic [13:0] mask);
    for (int k = 1; k < 14; k++) begin
      int i = (cur + k) % 14;
      if (mask[i]) return i;
    end
    return cur;
  endfunction

  task automatic step(input bit ln, input bit ad, input bit ic, input bit hs, input string tg);
    bit pa_ev, pi_ev, e_upd, e_req;
    string tf, tc, tl, ts, tu, tn;
    @(negedge clk);
    line_sel = ln; adv_btn = ad; inc_btn = ic; host_mode = hs; tick = 1'b1;
    e_upd = 0; e_req = 0;
    pa_ev = ad && !m_pa;
    pi_ev = ic && !m_pi;
    if (!hs) begin
      m_line = ln;
      if (pi_ev) begin
        if (ln) begin
          m_dig[m_cur] = (m_dig[m_cur] == 9) ? 0 : m_dig[m_cur] + 1;
          e_upd = 1;
        end else begin
          int ns = next_slot(m_slot, slot_mask);
          if (ns != m_slot) begin e_req = 1; e_upd = 1; end
          m_slot = ns;
        end
      end
      if (pa_ev && ln) m_cur = (m_cur == 5) ? 0 : m_cur + 1;
    end
    m_pa = ad; m_pi = ic;
    tf = "R5"; tc = "R3"; tl = "R2"; ts = "R6"; tu = "R10"; tn = "R9";
    if (tg != "") begin tf = tg; tc = tg; tl = tg; ts = tg; tu = tg; tn = tg; end
    @(negedge clk);
    tick = 1'b0;
    chk(tf, "freq_bcd", int'(freq_bcd), model_bcd());
    chk(tc, "cursor_digit", int'(cursor_digit), m_cur);
    chk(tl, "cursor_line", int'(cursor_line), m_line);
    chk(ts, "slot", int'(slot), m_slot);
    chk(ts, "slot_req", int'(slot_req), int'(e_req));
    chk(tu, "upd_pulse", int'(upd_pulse), int'(e_upd));
    @(negedge clk);
    chk(tn, "nco_inc", int'(nco_inc), model_inc());
    chk(tu, "upd_pulse low", int'(upd_pulse), 0);
  endtask

  task automatic press(input bit ln, input bit is_inc, input string tg);
    step(ln, !is_inc, is_inc, 1'b0, tg);
    step(ln, 1'b0, 1'b0, 1'b0, tg);
  endtask

  task automatic goto_freq(input int tenths, input string tg);
    for (int k = 0; k < 6; k++) begin
      int want = (tenths / (10 ** (5 - k))) % 10;
      while (m_cur != k) press(1'b1, 1'b0, tg);
      while (m_dig[k] != want) press(1'b1, 1'b1, tg);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd5150);
    m_dig = '{0, 1, 0, 0, 0, 0};
    m_cur = 0; m_line = 0; m_slot = 0; m_pa = 0; m_pi = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "freq_bcd", int'(freq_bcd), 32'h010000);
    chk("R1", "slot", int'(slot), 0);
    chk("R1", "cursor_line", int'(cursor_line), 0);
    chk("R1", "cursor_digit", int'(cursor_digit), 0);
    chk("R1", "nco_inc", int'(nco_inc), 10000);
    chk("R1", "upd_pulse", int'(upd_pulse), 0);
    chk("R1", "slot_req", int'(slot_req), 0);

    // R4 advance on waveform line does nothing
    press(1'b0, 1'b0, "R4");
    chk("R4", "cursor_digit", int'(cursor_digit), 0);
    // R2 line switch
    step(1'b1, 1'b0, 1'b0, 1'b0, "R2");
    // R7 held button acts once
    step(1'b1, 1'b0, 1'b1, 1'b0, "R7");
    step(1'b1, 1'b0, 1'b1, 1'b0, "R7");
    step(1'b1, 1'b0, 1'b1, 1'b0, "R7");
    chk("R7", "freq_bcd held", int'(freq_bcd), 32'h110000);
    step(1'b1, 1'b0, 1'b0, 1'b0, "R7");
    // R3 cursor wrap across all six positions
    for (int i = 0; i < 6; i++) press(1'b1, 1'b0, "R3");
    chk("R3", "cursor wrap", int'(cursor_digit), 0);
    // R11 both pressed together
    step(1'b1, 1'b1, 1'b1, 1'b0, "R11");
    chk("R11", "digit0 bumped", int'(freq_bcd[23:20]), 2);
    chk("R11", "cursor moved", int'(cursor_digit), 1);
    step(1'b1, 1'b0, 1'b0, 1'b0, "R11");
    // R5 nine to zero without carry
    goto_freq(9, "R5");
    press(1'b1, 1'b1, "R5");
    chk("R5", "no carry", int'(freq_bcd), 0);
    // R9 clamps
    chk("R9", "zero clamps to one", int'(nco_inc), 1);
    goto_freq(200001, "R9");
    chk("R9", "upper clamp", int'(nco_inc), 200000);
    goto_freq(999999, "R9");
    chk("R9", "max digits clamp", int'(nco_inc), 200000);
    goto_freq(123456, "R9");
    chk("R9", "plain value", int'(nco_inc), 123456);
    // R8 host mode freezes
    step(1'b1, 1'b1, 1'b0, 1'b1, "R8");
    step(1'b0, 1'b0, 1'b1, 1'b1, "R8");
    chk("R8", "line frozen", int'(cursor_line), 1);
    step(1'b0, 1'b0, 1'b0, 1'b0, "R8");
    // R6 slot search with wrap
    slot_mask = 14'b10_0000_0000_0101;
    press(1'b0, 1'b1, "R6");
    chk("R6", "slot 2", int'(slot), 2);
    press(1'b0, 1'b1, "R6");
    chk("R6", "slot 13", int'(slot), 13);
    press(1'b0, 1'b1, "R6");
    chk("R6", "wrap to 0", int'(slot), 0);
    slot_mask = 14'b00_0000_0000_0001;
    press(1'b0, 1'b1, "R6");
    chk("R6", "sole slot kept", int'(slot), 0);
    slot_mask = '0;
    press(1'b0, 1'b1, "R6");
    chk("R6", "empty mask kept", int'(slot), 0);

    // constrained random mix
    for (int i = 0; i < 600; i++) begin
      if ((i % 40) == 0) slot_mask = 14'($urandom);
      step(1'($urandom), 1'($urandom), 1'($urandom), ($urandom % 8) == 0, "");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule